// File: doc/BRIEF.md
# Byte-Wide Indirect Register Access Sequencer

This block gives a host a simple request interface to a byte-wide peripheral register space that sits behind a shared access port. The host gives a read or write command with an 18-bit register address and, for a write, one data byte. The sequencer runs the access as three steps:

- It sets up the address on a latched address bus while every control line stays low.
- It raises the port select together with a read or write direction line, and puts the data byte on the port for a write. It holds this strobe phase for a fixed number of clock cycles.
- It drops the whole control word back to zero and reports completion with a one-cycle done pulse.

On a read, the byte that the peripheral returns is sampled in the last strobe cycle and is presented with the done pulse.

The sequencer handles one access at a time. While an access is in flight it shows busy and withholds request-ready, and any request seen in that time is dropped. Arbitration between several hosts belongs to the logic in front of this block.

Top module: `indirect_byte_access`

## Requirements
- R1: Reset is synchronous and active-low on `rst_n`. After a clock edge with `rst_n` low, `busy`, `done`, `done_rdata`, `rom_addr`, `rom_sel`, `rom_rd`, `rom_wr` and `rom_wdata` are all zero and `req_ready` is one, including when reset arrives in the middle of an access.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the following cycle `rom_addr` equals the request address, `rom_sel` is low and `busy` is high.
- R3: Starting in the cycle after the address setup, `rom_sel` stays high for exactly `WAIT_CYCLES` consecutive cycles (default 20). During that window exactly one of `rom_rd` (read, `req_write`=0) and `rom_wr` (write, `req_write`=1) is high.
- R4: During a write strobe, `rom_wdata` carries the request data byte. During a read strobe and at every other time, `rom_wdata` is zero.
- R5: On a read, `done_rdata` returns the value that `rom_rdata` had in the last strobe cycle. Values that `rom_rdata` shows in earlier strobe cycles have no effect.
- R6: In the cycle after the strobe ends, `rom_sel`, `rom_rd`, `rom_wr` and `rom_wdata` are all zero and `done` is high for exactly one cycle. In the cycle after that, the block is idle again.
- R7: `busy` is high and `req_ready` is low from the cycle after acceptance through the done cycle, `WAIT_CYCLES`+2 cycles in all. A request raised in that time is ignored: `rom_addr` keeps the accepted address and no second access follows.
- R8: After a write, `done_rdata` is zero in the done cycle.
- R9: After the access, `rom_addr` keeps the accessed address until the next request is accepted. Request inputs that change after acceptance do not alter the access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Register address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Block can take a request |
| busy | output | 1 | Access in flight |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 8 | Read byte (zero after a write) |
| rom_addr | output | 18 | Latched port address |
| rom_sel | output | 1 | Port select |
| rom_rd | output | 1 | Read direction strobe |
| rom_wr | output | 1 | Write direction strobe |
| rom_wdata | output | 8 | Byte driven to the port |
| rom_rdata | input | 8 | Byte returned by the port |

## Verification
The assertions assume only that reset is applied before the first checked cycle. They place no limit on `req_valid`, because the block must tolerate requests at any time. They do assume that `rom_rdata` is a plain data input with no protocol of its own.

The stimulus follows these assumptions:
- Requests are driven on the falling edge and held for one cycle.
- Intruding requests are raised deliberately while busy, to show they are dropped.
- A decoy byte sits on `rom_rdata` for most of each strobe. The true byte appears only in the final strobe cycle, so a capture taken too early shows up as a wrong value.

// File: rtl/iba_pkg.sv
// Shared types for the indirect byte access sequencer.
// Assumes: nothing beyond being compiled first.
package iba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_STROBE = 2'd2,
        ST_CLEAR  = 2'd3
    } iba_state_e;
endpackage

// File: rtl/iba_addr_latch.sv
// Address register for the peripheral port.
// Loads the request address on acceptance and holds it until the next load.
// Assumes: load is only raised when a request is accepted.
module iba_addr_latch #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);
    // Capture the address on load; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load)
            addr_q <= addr_in;
    end
endmodule

// File: rtl/iba_strobe_timer.sv
// Counts the cycles of the strobe phase.
// Flags the last cycle once the strobe has been high WAIT_CYCLES cycles.
// Assumes: WAIT_CYCLES >= 1, and run stays high for the whole strobe.
module iba_strobe_timer #(
    parameter int WAIT_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count strobe cycles; restart whenever the strobe is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Mark the final strobe cycle.
    always_comb last = run && (cnt == LAST_CNT);
endmodule

// File: rtl/iba_seq_fsm.sv
// Access sequencer: idle -> address setup -> strobe -> clear.
// Drives the port control word, captures read data and pulses done.
// Assumes: strobe_last comes from a timer that runs while in ST_STROBE.
module iba_seq_fsm
    import iba_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              strobe_last,
    input  logic [DATA_W-1:0] rom_rdata,
    output iba_state_e        state,
    output logic              load_addr,
    output logic              rom_sel,
    output logic              rom_rd,
    output logic              rom_wr,
    output logic [DATA_W-1:0] rom_wdata,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata
);
    logic              dir_wr;
    logic [DATA_W-1:0] wbyte;

    // Accept a request only in idle.
    always_comb load_addr = (state == ST_IDLE) && req_valid;

    // State sequencing and registered control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            dir_wr     <= 1'b0;
            wbyte      <= '0;
            rom_sel    <= 1'b0;
            rom_rd     <= 1'b0;
            rom_wr     <= 1'b0;
            rom_wdata  <= '0;
            done       <= 1'b0;
            done_rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    done <= 1'b0;
                    if (req_valid) begin
                        state  <= ST_ADDR;
                        dir_wr <= req_write;
                        wbyte  <= req_wdata;
                    end
                end
                ST_ADDR: begin
                    state     <= ST_STROBE;
                    rom_sel   <= 1'b1;
                    rom_rd    <= !dir_wr;
                    rom_wr    <= dir_wr;
                    rom_wdata <= dir_wr ? wbyte : '0;
                end
                ST_STROBE: begin
                    if (strobe_last) begin
                        state      <= ST_CLEAR;
                        rom_sel    <= 1'b0;
                        rom_rd     <= 1'b0;
                        rom_wr     <= 1'b0;
                        rom_wdata  <= '0;
                        done       <= 1'b1;
                        done_rdata <= dir_wr ? '0 : rom_rdata;
                    end
                end
                default: begin
                    done  <= 1'b0;
                    state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/indirect_byte_access.sv
// Top of the indirect byte access sequencer.
// Takes one host request at a time and runs it as address setup, a fixed-length strobe and a clear step.
// Assumes: a single host; rom_rdata is valid by the final strobe cycle.
module indirect_byte_access
    import iba_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 8,
    parameter int WAIT_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_sel,
    output logic              rom_rd,
    output logic              rom_wr,
    output logic [DATA_W-1:0] rom_wdata,
    input  logic [DATA_W-1:0] rom_rdata
);
    iba_state_e state;
    logic       load_addr;
    logic       strobe_last;
    logic       strobe_run;

    // Status seen by the host.
    always_comb begin
        busy       = (state != ST_IDLE);
        req_ready  = !busy;
        strobe_run = (state == ST_STROBE);
    end

    iba_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_addr),
        .addr_in(req_addr),
        .addr_q (rom_addr)
    );

    iba_strobe_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (strobe_run),
        .last (strobe_last)
    );

    iba_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .strobe_last(strobe_last),
        .rom_rdata  (rom_rdata),
        .state      (state),
        .load_addr  (load_addr),
        .rom_sel    (rom_sel),
        .rom_rd     (rom_rd),
        .rom_wr     (rom_wr),
        .rom_wdata  (rom_wdata),
        .done       (done),
        .done_rdata (done_rdata)
    );
endmodule

// File: rtl/iba_checker.sv
// Protocol checks for the indirect byte access sequencer, bound to its top.
// Assumes: reset is applied before the first checked cycle.
module iba_checker #(
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 8,
    parameter int WAIT_CYCLES = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_sel,
    input logic              rom_rd,
    input logic              rom_wr,
    input logic [DATA_W-1:0] rom_wdata
);
    localparam int RW = $clog2(WAIT_CYCLES + 2);
    logic [RW-1:0] sel_run;

    // Length of the current run of select-high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !rom_sel)
            sel_run <= '0;
        else
            sel_run <= sel_run + 1'b1;
    end

    // R3
    sel_dir_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> $countones({rom_rd, rom_wr}) == 1);
    // R6
    ctrl_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel |-> (!rom_rd && !rom_wr && rom_wdata == '0));
    // R4
    read_no_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> rom_wdata == '0);
    // R9
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> $stable(rom_addr));
    // R2
    accept_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !rom_sel));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    strobe_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> sel_run < RW'(WAIT_CYCLES));
    // R3
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sel_run == RW'(WAIT_CYCLES));
endmodule

bind indirect_byte_access iba_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CYCLES(WAIT_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .busy(busy), .done(done), .rom_addr(rom_addr), .rom_sel(rom_sel),
    .rom_rd(rom_rd), .rom_wr(rom_wr), .rom_wdata(rom_wdata)
);

// File: tb/indirect_byte_access_tb.sv
module indirect_byte_access_tb;
    localparam int AW = 18;
    localparam int DW = 8;
    localparam int WAITC = 20;
    localparam int NV = 6;
    // vector: {write, addr[17:0], wdata[7:0], rdata[7:0], decoy[7:0]}
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 18'h00000, 8'h00, 8'hA5, 8'h5A},
        {1'b1, 18'h3FFFF, 8'hFF, 8'h00, 8'h11},
        {1'b0, 18'h2AAAA, 8'h00, 8'hFF, 8'h00},
        {1'b1, 18'h15555, 8'h3C, 8'h77, 8'h88},
        {1'b0, 18'h00401, 8'h99, 8'h01, 8'hFE},
        {1'b1, 18'h20000, 8'h01, 8'hC3, 8'h3C}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, rom_rdata = '0;
    logic req_ready, busy, done, rom_sel, rom_rd, rom_wr;
    logic [DW-1:0] done_rdata, rom_wdata;
    logic [AW-1:0] rom_addr;
    int n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    indirect_byte_access #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYCLES(WAITC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .busy(busy), .done(done), .done_rdata(done_rdata), .rom_addr(rom_addr),
        .rom_sel(rom_sel), .rom_rd(rom_rd), .rom_wr(rom_wr),
        .rom_wdata(rom_wdata), .rom_rdata(rom_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_idle_zero(input string tag);
        chk({tag, " busy"}, 32'(busy), 0);
        chk({tag, " ready"}, 32'(req_ready), 1);
        chk({tag, " done"}, 32'(done), 0);
        chk({tag, " ctrl"}, {rom_sel, rom_rd, rom_wr, rom_wdata}, 0);
    endtask

    task automatic run_access(input logic wr, input logic [AW-1:0] a,
                              input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                              input logic [DW-1:0] decoy, input bit intrude);
        int scount = 0;
        bit seen = 0;
        @(negedge clk);
        chk("R7 ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; rom_rdata = decoy;
        @(negedge clk);
        req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~wd;
        chk("R2 addr setup", 32'(rom_addr), 32'(a));
        chk("R2 sel low in setup", 32'(rom_sel), 0);
        chk("R7 busy", {busy, req_ready}, 32'b10);
        for (int i = 0; i < WAITC + 4 && !seen; i++) begin
            @(negedge clk);
            if (rom_sel) begin
                scount++;
                if (intrude && scount == 3) begin
                    req_valid = 1'b1; req_addr = a ^ 18'h00F0F;
                end else req_valid = 1'b0;
                if (scount == 5) begin
                    chk("R3 dir", {rom_rd, rom_wr}, {30'b0, ~wr, wr});
                    chk("R4 wdata", 32'(rom_wdata), wr ? 32'(wd) : 0);
                    chk("R7 busy in strobe", {busy, req_ready}, 32'b10);
                    chk("R9 addr held in strobe", 32'(rom_addr), 32'(a));
                end
                if (scount == WAITC) rom_rdata = rd;
            end else if (done) begin
                seen = 1;
                req_valid = 1'b0;
                chk("R6 ctrl cleared", {rom_sel, rom_rd, rom_wr, rom_wdata}, 0);
                chk("R3 strobe length", 32'(scount), 32'(WAITC));
                if (wr) chk("R8 write rdata zero", 32'(done_rdata), 0);
                else    chk("R5 read capture", 32'(done_rdata), 32'(rd));
                chk("R7 busy at done", 32'(busy), 1);
            end
        end
        chk("R6 done seen", 32'(seen), 1);
        @(negedge clk);
        chk("R6 done single", 32'(done), 0);
        chk("R7 idle after", {busy, req_ready}, 32'b01);
        chk("R9 addr kept", 32'(rom_addr), 32'(a));
        if (intrude) begin
            @(negedge clk);
            chk("R7 no second access", {busy, rom_sel}, 0);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_idle_zero("R1 reset");
        chk("R1 addr", 32'(rom_addr), 0);
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++)
            run_access(VEC[v][42], VEC[v][41:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 1'b0);
        // R7 request while busy is dropped
        run_access(1'b0, 18'h1234C, 8'h00, 8'h6D, 8'h92, 1'b1);
        // R1 reset in the middle of an access
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h0BEEF; req_wdata = 8'h44;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk("R1 pre-reset strobe", 32'(rom_sel), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle_zero("R1 mid reset");
        chk("R1 mid reset addr", {rom_addr, done_rdata}, 0);
        rst_n = 1'b1;
        // back-to-back after reset still works
        run_access(1'b0, 18'h00077, 8'h00, 8'h42, 8'hBD, 1'b0);
        finish_run();
    end
endmodule